// File: doc/BRIEF.md
# Low-Speed Clock Source Switchover Controller

This controller decides whether the 32.768 kHz low-speed clock of a chip comes from the on-die low-speed oscillator or from an external watch crystal. Software writes two small registers over a simple write port. The control register holds an enable bit for the crystal and a two-bit sleep-interval code, which goes out to the sleep timer. The status register holds a one-time "crystal present" permission bit and a flag that records that the permission has been written. The block drives the crystal-oscillator enable, the internal-oscillator enable and the select line of the low-speed clock mux.

Enabling the crystal starts the crystal oscillator at once, but the mux keeps the internal oscillator selected. The mux moves to the crystal only on a later sleep-timer interrupt pulse. Software sets that interrupt to a one-second interval so that it covers the crystal's start-up time. Clearing the enable returns the mux to the internal oscillator on the same clock edge as the write, and it also cancels a switchover that is still waiting for its interrupt. No switchover can happen unless the permission bit was written as 1. Software can write the permission bit only once after each reset.

Top module: `lsclk_switch_ctrl`

## Requirements
- R1: After reset, eco_en is 0, ilo_en is 1 and clk_sel is 0 (0 means the internal oscillator). Both registers read 0.
- R2: The control register is at address 0. A write captures bit 7 (crystal enable) and bits [4:3] (sleep interval). A read returns only those bits, with all other bits 0. sleep_sel always equals the stored bits [4:3].
- R3: While permission is 1, a control write that sets bit 7 raises eco_en on that write's clock edge. clk_sel stays 0 and ilo_en stays 1 until the switchover interrupt arrives.
- R4: While waiting, the first sleep_irq sampled on a later clock edge sets clk_sel to 1 and ilo_en to 0 on that edge. A sleep_irq on the same edge as the enabling write does not switch.
- R5: While the crystal is selected, a control write with bit 7 clear sets clk_sel to 0, ilo_en to 1 and eco_en to 0 on the write's own edge.
- R6: Clearing bit 7 while waiting cancels the switchover. A later sleep_irq leaves clk_sel at 0.
- R7: While the permission bit is 0, a set enable bit does not change eco_en, ilo_en or clk_sel, and sleep_irq has no effect either.
- R8: The status register is at address 1. The first write after reset stores data bit 2 as the permission bit and sets the written flag. A read returns the written flag at bit 3 and permission at bit 2. Later writes leave both unchanged.
- R9: Only reset clears the permission bit and the written flag. Reset also returns the outputs to the R1 state from any state.
- R10: sleep_irq has no effect while the crystal is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset (power-on or external) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 status |
| rd_data | output | 8 | Read data for rd_addr |
| sleep_irq | input | 1 | Sleep-timer interrupt pulse |
| sleep_sel | output | 2 | Sleep interval code to the sleep timer |
| eco_en | output | 1 | Crystal oscillator enable |
| ilo_en | output | 1 | Internal low-speed oscillator enable |
| clk_sel | output | 1 | Low-speed mux select, 1 = crystal |

## Verification
The state machine's state is visible at all times through the three output enables. A wrong state shows up on eco_en, ilo_en or clk_sel on the clock edge after the event that caused it, whether that event is a write or an interrupt. A register fault shows up on the next read of rd_data, which is combinational. A permission latch that does not hold shows up when a second status write changes the read-back value, or when an enable with no permission starts the crystal. A switchover taken too early shows up when clk_sel rises without an interrupt on the edge before it.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

    // Register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Field positions (software-visible, fixed)
    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_IV_LO   = 3;
    localparam int CTRL_IV_W    = 2;
    localparam int CTRL_IV_HI   = CTRL_IV_LO + CTRL_IV_W - 1;
    localparam int STAT_EX_BIT  = 2;
    localparam int STAT_WR_BIT  = 3;

    typedef enum logic [1:0] {
        SRC_ILO  = 2'd0,
        SRC_WAIT = 2'd1,
        SRC_ECO  = 2'd2
    } src_state_e;

    typedef struct packed {
        logic                 en;
        logic [CTRL_IV_W-1:0] ival;
        logic                 exists;
        logic                 written;
    } reg_state_t;

    typedef struct packed {
        src_state_e state;
        logic       eco;
        logic       ilo;
        logic       sel;
    } fsm_state_t;

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 en_nxt,
    output logic [CTRL_IV_W-1:0] ival,
    output logic                 exists,
    output logic                 written
);

    reg_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                r_d.en   = wr_data[CTRL_EN_BIT];
                r_d.ival = wr_data[CTRL_IV_HI:CTRL_IV_LO];
            end else if (!r_q.written) begin
                r_d.exists  = wr_data[STAT_EX_BIT];
                r_d.written = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data[CTRL_EN_BIT]            = r_q.en;
            rd_data[CTRL_IV_HI:CTRL_IV_LO]  = r_q.ival;
        end else begin
            rd_data[STAT_WR_BIT] = r_q.written;
            rd_data[STAT_EX_BIT] = r_q.exists;
        end
    end

    logic unused_wr_bits;
    assign unused_wr_bits = &{1'b0, wr_data};

    assign en_nxt  = r_d.en;
    assign ival    = r_q.ival;
    assign exists  = r_q.exists;
    assign written = r_q.written;

endmodule

// File: rtl/lsclk_fsm.sv
module lsclk_fsm
    import lsclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt,
    input  logic exists,
    input  logic sleep_irq,
    output logic eco_en,
    output logic ilo_en,
    output logic clk_sel
);

    localparam fsm_state_t RESET_VAL = '{state: SRC_ILO, eco: 1'b0, ilo: 1'b1, sel: 1'b0};

    fsm_state_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            SRC_ILO:  if (en_nxt && exists) f_d.state = SRC_WAIT;
            SRC_WAIT: begin
                if (!en_nxt)        f_d.state = SRC_ILO;
                else if (sleep_irq) f_d.state = SRC_ECO;
            end
            SRC_ECO:  if (!en_nxt) f_d.state = SRC_ILO;
            default:  f_d.state = SRC_ILO;
        endcase

        unique case (f_d.state)
            SRC_WAIT: begin f_d.eco = 1'b1; f_d.ilo = 1'b1; f_d.sel = 1'b0; end
            SRC_ECO:  begin f_d.eco = 1'b1; f_d.ilo = 1'b0; f_d.sel = 1'b1; end
            default:  begin f_d.eco = 1'b0; f_d.ilo = 1'b1; f_d.sel = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= RESET_VAL;
        end else begin
            f_q <= f_d;
        end
    end

    assign eco_en  = f_q.eco;
    assign ilo_en  = f_q.ilo;
    assign clk_sel = f_q.sel;

endmodule

// File: rtl/lsclk_switch_ctrl.sv
module lsclk_switch_ctrl
    import lsclk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 sleep_irq,
    output logic [CTRL_IV_W-1:0] sleep_sel,
    output logic                 eco_en,
    output logic                 ilo_en,
    output logic                 clk_sel
);

    logic en_nxt_w;
    logic exists_w;
    logic written_w;

    lsclk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en_nxt  (en_nxt_w),
        .ival    (sleep_sel),
        .exists  (exists_w),
        .written (written_w)
    );

    lsclk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_nxt    (en_nxt_w),
        .exists    (exists_w),
        .sleep_irq (sleep_irq),
        .eco_en    (eco_en),
        .ilo_en    (ilo_en),
        .clk_sel   (clk_sel)
    );

endmodule

// File: rtl/lsclk_switch_chk.sv
module lsclk_switch_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sleep_irq,
    input logic              eco_en,
    input logic              ilo_en,
    input logic              clk_sel,
    input logic              exists,
    input logic              written
);

    // R4
    sel_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel) |-> $past(sleep_irq));

    // R3
    sel_needs_eco_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel |-> (eco_en && !ilo_en));

    // R1
    clock_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eco_en |-> ilo_en);

    // R5
    revert_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && !wr_data[7]) |=> (!clk_sel && !eco_en && ilo_en));

    // R7
    locked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exists |-> (!eco_en && !clk_sel));

    // R8
    write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        written |=> (written && $stable(exists)));

endmodule

bind lsclk_switch_ctrl lsclk_switch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sleep_irq (sleep_irq),
    .eco_en    (eco_en),
    .ilo_en    (ilo_en),
    .clk_sel   (clk_sel),
    .exists    (exists_w),
    .written   (written_w)
);

// File: tb/test_lsclk_switch_ctrl.sv
`timescale 1ns/1ps
module test_lsclk_switch_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       sleep_irq = 1'b0;
    logic [1:0] sleep_sel;
    logic       eco_en, ilo_en, clk_sel;

    int n_chk = 0;
    int n_bad = 0;

    // outputs packed as {eco_en, ilo_en, clk_sel}
    localparam logic [2:0] O_ILO  = 3'b010;
    localparam logic [2:0] O_WAIT = 3'b110;
    localparam logic [2:0] O_ECO  = 3'b101;

    always #2.5 clk = ~clk;

    lsclk_switch_ctrl i_lsclk_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sleep_irq(sleep_irq), .sleep_sel(sleep_sel),
        .eco_en(eco_en), .ilo_en(ilo_en), .clk_sel(clk_sel)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [2:0] exp);
        check(req, {5'b0, eco_en, ilo_en, clk_sel}, {5'b0, exp});
    endtask

    task automatic chk_rd(string req, logic a, logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic a, logic [7:0] d, logic irq = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; sleep_irq = irq;
        @(negedge clk);
        wr_en = 1'b0; sleep_irq = 1'b0;
    endtask

    task automatic irq_pulse();
        @(negedge clk);
        sleep_irq = 1'b1;
        @(negedge clk);
        sleep_irq = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R1 outputs", O_ILO);
        chk_rd("R1 ctrl", 1'b0, 8'h00);
        chk_rd("R1 status", 1'b1, 8'h00);
    endtask

    task automatic t_regs_locked();
        wr(1'b0, 8'hFF);
        chk_rd("R2 ctrl readback", 1'b0, 8'h98);
        check("R2 sleep_sel", {6'b0, sleep_sel}, 8'h03);
        chk_out("R7 enable without permission", O_ILO);
        wr(1'b1, 8'h00);
        chk_rd("R8 first status write", 1'b1, 8'h08);
        wr(1'b1, 8'h04);
        chk_rd("R8 second write ignored", 1'b1, 8'h08);
        irq_pulse();
        chk_out("R7 irq while locked", O_ILO);
        wr(1'b0, 8'h08);
        chk_rd("R2 ctrl interval only", 1'b0, 8'h08);
        check("R2 sleep_sel 1", {6'b0, sleep_sel}, 8'h01);
    endtask

    task automatic t_permit();
        do_reset();
        chk_rd("R9 status cleared by reset", 1'b1, 8'h00);
        wr(1'b1, 8'h04);
        chk_rd("R8 permission set", 1'b1, 8'h0C);
        wr(1'b1, 8'h00);
        chk_rd("R8 permission held", 1'b1, 8'h0C);
        irq_pulse();
        chk_out("R10 irq while disabled", O_ILO);
    endtask

    task automatic t_switch();
        wr(1'b0, 8'h98);
        chk_out("R3 enable starts crystal only", O_WAIT);
        repeat (3) @(negedge clk);
        chk_out("R3 still waiting", O_WAIT);
        irq_pulse();
        chk_out("R4 switch on irq", O_ECO);
        wr(1'b0, 8'h18);
        chk_out("R5 immediate revert", O_ILO);
        chk_rd("R5 ctrl after clear", 1'b0, 8'h18);
    endtask

    task automatic t_cancel();
        wr(1'b0, 8'h98);
        chk_out("R6 waiting", O_WAIT);
        wr(1'b0, 8'h18);
        chk_out("R6 cancelled", O_ILO);
        irq_pulse();
        chk_out("R6 irq after cancel", O_ILO);
    endtask

    task automatic t_same_edge();
        wr(1'b0, 8'h98, 1'b1);
        chk_out("R4 irq on enabling edge ignored", O_WAIT);
        irq_pulse();
        chk_out("R4 next irq switches", O_ECO);
        do_reset();
        chk_out("R9 reset from crystal", O_ILO);
        chk_rd("R9 status after reset", 1'b1, 8'h00);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs_locked();
        t_permit();
        t_switch();
        t_cancel();
        t_same_edge();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule